// File: doc/BRIEF.md
# Command-Steered Serial Register Port

This block is the serial slave port in front of a converter's register bank. A host reaches a register in two steps. It first shifts in an 8-bit command byte. That byte names one of eight registers, says whether the next access reads or writes it, and picks an input channel. The port then performs exactly that one access, whose length depends on the register, and afterwards waits for the next command byte. Transfers are half-duplex and MSB first. The clock polarity is chosen by a static pin. A chip-select input aborts an access when it is raised, but the port also frames transfers correctly when chip select is tied low.

The host clock, chip select and serial data are synchronised into the system clock domain. Bits are sampled on the edge that returns the serial clock to its idle level, and read data is driven on the edge that leaves it. A one-cycle result strobe stands in for the conversion engine. It loads the data register and pulls the ready output low. The ready flag can also be read as the top bit of the command register.

Top module: `steered_serial_port`

## Requirements
- R1: After reset the port waits for a command byte, `drdy_n` is 1, `dout` and `dout_en` are 0, and the three 8-bit setup registers read back as: select 001 = 0x00, select 010 = 0x01, select 011 = 0x40.
- R2: A command byte has bit 7 ignored on write, bits 6:4 = register select, bit 3 = read (1) or write (0), and bits 2:0 = channel. Every command arms exactly one access and then the port waits for a command again. A command that selects register 000 for writing arms nothing, so the next byte is again a command.
- R3: `dout_en` is high only during a read access with chip select low, and `dout` is 0 whenever `dout_en` is low. Data on `din` during a read access has no effect.
- R4: Serial data moves most significant bit first in both directions.
- R5: Selects 101, 110 and 111 are DATA_W bits long and all other selects are 8 bits long. A long access may be split into 8-bit pieces with the serial clock held idle between them, as long as chip select stays low.
- R6: A command byte followed at once by its access forms one continuous transfer of 8 plus the access length in clocks.
- R7: A result strobe loads `conv_result` into register 101 and drives `drdy_n` low on the next cycle. `drdy_n` returns high only after the last bit of a complete read of register 101. If both happen in the same cycle, the strobe wins.
- R8: A read of register 000 returns {`drdy_n`, select, read bit, channel} taken from the command that requested it.
- R9: Raising `cs_n` during a command or an access cancels it, leaves the target register unchanged, and returns the port to waiting for a command.
- R10: With `pol` = 0 the serial clock idles low, `din` is sampled on falling edges and `dout` changes on rising edges. With `pol` = 1 both edges are reversed.
- R11: Register 101 is read-only. A write access to it is clocked through but leaves its contents unchanged.
- R12: `chan` equals the channel field of the most recent complete command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pol | input | 1 | Serial clock idle level (static) |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_en | output | 1 | High while the port is driving read data |
| drdy_n | output | 1 | Low while an unread result is held |
| conv_strobe | input | 1 | One-cycle pulse that delivers a new result |
| conv_result | input | DATA_W | Result value loaded by the strobe |
| chan | output | 3 | Channel field of the last command |

## Verification
The bench builds the port with DATA_W = 24 and SYNC_STAGES = 2, and each serial half-period lasts six system clocks. With those values a 24-bit access is long enough to be split into three bytes, so the pause rules and the moment the ready flag releases after the third byte can be observed. The setting also leaves enough slack after the two-stage synchroniser to run a command byte and a 24-bit access back to back under both clock polarities. A model in the bench tracks the register contents, the ready flag and the channel, and checks the ready output against that model on every settled clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [2:0] {
    SEL_COMM = 3'd0,
    SEL_MODE = 3'd1,
    SEL_FHI  = 3'd2,
    SEL_FLO  = 3'd3,
    SEL_TEST = 3'd4,
    SEL_DATA = 3'd5,
    SEL_ZCAL = 3'd6,
    SEL_FCAL = 3'd7
  } reg_sel_e;

  // command byte without its top (status) bit
  typedef struct packed {
    reg_sel_e   sel;
    logic       rd;
    logic [2:0] ch;
  } cmd_t;

  function automatic logic is_wide(reg_sel_e s);
    return (s == SEL_DATA) || (s == SEL_ZCAL) || (s == SEL_FCAL);
  endfunction

  function automatic int unsigned access_len(reg_sel_e s, int unsigned wide_w);
    return is_wide(s) ? wide_w : CMD_W;
  endfunction

  // a write aimed at the command register itself arms no access
  function automatic logic arms_access(cmd_t c);
    return c.rd || (c.sel != SEL_COMM);
  endfunction
endpackage

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sample_pulse,
  output logic drive_pulse,
  output logic cs_active,
  output logic din_s
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_q, cs_q, din_q;
  logic sclk_prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= {STAGES{pol}};
      cs_q      <= '1;
      din_q     <= '0;
      sclk_prev <= pol;
    end else begin
      sclk_q    <= {sclk_q[STAGES-2:0], sclk};
      cs_q      <= {cs_q[STAGES-2:0], cs_n};
      din_q     <= {din_q[STAGES-2:0], din};
      sclk_prev <= sclk_q[TOP];
    end
  end

  assign rise         = sclk_q[TOP] & ~sclk_prev;
  assign fall         = ~sclk_q[TOP] & sclk_prev;
  // sample when the clock returns to idle, drive when it leaves idle
  assign sample_pulse = pol ? rise : fall;
  assign drive_pulse  = pol ? fall : rise;
  assign cs_active    = ~cs_q[TOP];
  assign din_s        = din_q[TOP];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_pulse,
  input  logic              drive_pulse,
  input  logic              cs_active,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_word,
  output cmd_t              next_cmd,
  output cmd_t              cmd_q,
  output logic              arm_next,
  output logic              phase_acc,
  output logic              cmd_done,
  output logic              acc_done,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              data_rd_done,
  output logic              dout,
  output logic              dout_en
);
  logic [DATA_W-2:0] rx_q;
  logic [DATA_W-1:0] tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic              phase_q;
  logic              dout_q;
  logic              last_bit;

  assign limit    = phase_q ? CNT_W'(access_len(cmd_q.sel, DATA_W)) : CNT_W'(CMD_W);
  assign last_bit = sample_pulse && cs_active && (cnt_q == limit - 1'b1);
  assign cmd_done = last_bit && !phase_q;
  assign acc_done = last_bit && phase_q;

  assign next_cmd = cmd_t'({rx_q[5:0], din_s});
  assign arm_next = arms_access(next_cmd);

  assign wr_data      = {rx_q, din_s};
  assign wr_en        = acc_done && !cmd_q.rd;
  assign data_rd_done = acc_done && cmd_q.rd && (cmd_q.sel == SEL_DATA);

  assign phase_acc = phase_q;
  assign dout_en   = phase_q && cmd_q.rd && cs_active;
  assign dout      = dout_q && dout_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      dout_q  <= 1'b0;
      cmd_q   <= '0;
    end else if (!cs_active) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      dout_q  <= 1'b0;
    end else begin
      if (sample_pulse) begin
        rx_q <= {rx_q[DATA_W-3:0], din_s};
        if (last_bit) begin
          cnt_q <= '0;
          if (!phase_q) begin
            cmd_q   <= next_cmd;
            phase_q <= arm_next;
            tx_q    <= rd_word;
          end else begin
            phase_q <= 1'b0;
            dout_q  <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (drive_pulse && phase_q && cmd_q.rd) begin
        dout_q <= tx_q[DATA_W-1];
        tx_q   <= tx_q << 1;
      end
    end
  end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  cmd_t              peek_cmd,
  input  logic              conv_strobe,
  input  logic [DATA_W-1:0] conv_result,
  input  logic              data_rd_done,
  output logic [DATA_W-1:0] rd_word,
  output logic              drdy_n
);
  localparam int unsigned NREG = 8;

  function automatic logic [DATA_W-1:0] reset_word(reg_sel_e s);
    case (s)
      SEL_FHI:  return DATA_W'(8'h01);
      SEL_FLO:  return DATA_W'(8'h40);
      SEL_ZCAL: return DATA_W'(1) << (DATA_W - 1);
      SEL_FCAL: return DATA_W'(5) << (DATA_W - 4);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(reg_sel_e s);
    return is_wide(s) ? '1 : DATA_W'(8'hFF);
  endfunction

  logic [DATA_W-1:0] bank [NREG];
  logic [DATA_W-1:0] raw;
  logic              drdy_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam reg_sel_e          SEL  = reg_sel_e'(g);
    localparam logic [DATA_W-1:0] INIT = reset_word(SEL);
    if (SEL == SEL_COMM) begin : g_none
      assign bank[g] = '0;
    end else if (SEL == SEL_DATA) begin : g_result
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)           q <= INIT;
        else if (conv_strobe) q <= conv_result;
      end
      assign bank[g] = q;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                        q <= INIT;
        else if (wr_en && wr_sel == SEL)   q <= wr_data & width_mask(SEL);
      end
      assign bank[g] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            drdy_q <= 1'b1;
    else if (conv_strobe)  drdy_q <= 1'b0;
    else if (data_rd_done) drdy_q <= 1'b1;
  end
  assign drdy_n = drdy_q;

  // read word left-aligned so the shifter always starts at its top bit
  always_comb begin
    if (peek_cmd.sel == SEL_COMM)
      raw = DATA_W'({drdy_q, peek_cmd.sel, peek_cmd.rd, peek_cmd.ch});
    else
      raw = bank[peek_cmd.sel];
    rd_word = is_wide(peek_cmd.sel) ? raw : (raw << (DATA_W - CMD_W));
  end
endmodule

// File: rtl/steered_serial_port.sv
module steered_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              drdy_n,
  input  logic              conv_strobe,
  input  logic [DATA_W-1:0] conv_result,
  output logic [2:0]        chan
);
  logic              sample_pulse, drive_pulse, cs_active, din_s;
  logic              cmd_done, acc_done, phase_acc, arm_next;
  logic              wr_en, data_rd_done;
  logic [DATA_W-1:0] wr_data, rd_word;
  cmd_t              next_cmd, cmd_q;

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pol(pol), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sample_pulse(sample_pulse), .drive_pulse(drive_pulse),
    .cs_active(cs_active), .din_s(din_s)
  );

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse), .drive_pulse(drive_pulse),
    .cs_active(cs_active), .din_s(din_s), .rd_word(rd_word),
    .next_cmd(next_cmd), .cmd_q(cmd_q), .arm_next(arm_next), .phase_acc(phase_acc),
    .cmd_done(cmd_done), .acc_done(acc_done), .wr_en(wr_en), .wr_data(wr_data),
    .data_rd_done(data_rd_done), .dout(dout), .dout_en(dout_en)
  );

  ssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(cmd_q.sel), .wr_data(wr_data),
    .peek_cmd(next_cmd), .conv_strobe(conv_strobe), .conv_result(conv_result),
    .data_rd_done(data_rd_done), .rd_word(rd_word), .drdy_n(drdy_n)
  );

  assign chan = cmd_q.ch;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst_n,
  input logic conv_strobe,
  input logic drdy_n,
  input logic dout,
  input logic dout_en,
  input logic cs_active,
  input logic cmd_done,
  input logic acc_done,
  input logic arm_next,
  input logic phase_acc,
  input logic data_rd_done
);
  assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);

  assert_drdy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(conv_strobe));

  assert_drdy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> ($past(data_rd_done) && !$past(conv_strobe)));

  assert_cmd_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && arm_next && cs_active) |=> phase_acc);

  assert_one_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !phase_acc);

  assert_cs_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (!phase_acc && !dout_en));
endmodule

bind steered_serial_port ssp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .drdy_n(drdy_n),
  .dout(dout), .dout_en(dout_en), .cs_active(cs_active), .cmd_done(cmd_done),
  .acc_done(acc_done), .arm_next(arm_next), .phase_acc(phase_acc),
  .data_rd_done(data_rd_done)
);

// File: tb/steered_serial_port_bench.sv
`timescale 1ns/1ps
module steered_serial_port_bench;
  localparam int DW = 24;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b0;
  logic din = 1'b0;
  logic conv_strobe = 1'b0;
  logic [DW-1:0] conv_result = '0;
  logic dout, dout_en, drdy_n;
  logic [2:0] chan;

  int checks = 0;
  int errors = 0;
  bit settled = 0;
  bit finished = 0;

  int   mreg [8];
  logic mdrdy;
  logic [2:0] mchan;

  always #10 clk = ~clk;

  steered_serial_port #(.DATA_W(DW), .SYNC_STAGES(2)) u_steered_serial_port (
    .clk(clk), .rst_n(rst_n), .pol(pol), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n), .conv_strobe(conv_strobe),
    .conv_result(conv_result), .chan(chan)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the ready flag against the model
  always @(negedge clk) begin
    if (settled && rst_n && !finished) begin
      checks++;
      if (drdy_n !== mdrdy) begin
        errors++;
        $display("FAIL R7 per-clock drdy_n: actual %0b expected %0b", drdy_n, mdrdy);
      end
    end
  end

  function automatic int len_of(input logic [2:0] sel);
    return (sel >= 3'd5) ? DW : 8;
  endfunction

  task automatic do_reset(input logic p);
    settled = 0;
    rst_n = 1'b0;
    pol = p;
    sclk = p;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    mreg[2] = 32'h01;
    mreg[3] = 32'h40;
    mreg[6] = 32'h800000;
    mreg[7] = 32'h500000;
    mdrdy = 1'b1;
    mchan = 3'd0;
    settled = 1;
  endtask

  // master shifts n bits MSB first; rdmode says dout_en must be high
  task automatic xfer(input int n, input logic [31:0] w, input bit rdmode, output logic [31:0] r);
    int bad = 0;
    r = '0;
    settled = 0;
    for (int i = 0; i < n; i++) begin
      din = w[n-1-i];
      sclk = ~pol;
      repeat (H) @(negedge clk);
      r = {r[30:0], dout};
      if (dout_en !== rdmode) bad++;
      if (!dout_en && dout) bad++;
      sclk = pol;
      repeat (H) @(negedge clk);
    end
    check(bad == 0, rdmode ? "R3 dout_en during read" : "R3 dout idle during write", bad, 0);
    settled = 1;
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [2:0] ch, input logic [31:0] val);
    int len = len_of(sel);
    logic [31:0] cmd = {24'd0, 1'b0, sel, 1'b0, ch};
    logic [31:0] r;
    xfer(8 + len, (cmd << len) | val, 1'b0, r);
    if (sel != 3'd0 && sel != 3'd5)
      mreg[sel] = (len == 8) ? (val & 32'hFF) : (val & 32'hFFFFFF);
    mchan = ch;
  endtask

  task automatic read_reg(input logic [2:0] sel, input logic [2:0] ch, input string tag);
    int len = len_of(sel);
    logic [31:0] r, exp;
    xfer(8, {24'd0, 1'b0, sel, 1'b1, ch}, 1'b0, r);
    mchan = ch;
    exp = (sel == 3'd0) ? {24'd0, mdrdy, sel, 1'b1, ch} : mreg[sel];
    xfer(len, 32'hFFFF_FFFF, 1'b1, r);
    check(r == exp, tag, r, exp);
    check(chan == mchan, "R12 chan after command", chan, mchan);
    if (sel == 3'd5) mdrdy = 1'b1;
  endtask

  task automatic strobe(input logic [DW-1:0] v);
    settled = 0;
    conv_result = v;
    conv_strobe = 1'b1;
    @(negedge clk);
    conv_strobe = 1'b0;
    mreg[5] = v;
    mdrdy = 1'b0;
    @(negedge clk);
    settled = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung (all requirements) actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, a, b, c;
    do_reset(1'b0);

    // R1 reset state
    check(drdy_n == 1'b1 && dout == 1'b0 && dout_en == 1'b0, "R1 reset outputs",
          {drdy_n, dout, dout_en}, 3'b100);
    read_reg(3'd1, 3'd5, "R1 mode reset value");
    read_reg(3'd2, 3'd7, "R1 filter-high reset value");
    read_reg(3'd3, 3'd0, "R1 filter-low reset value");

    // R6 and R4: command plus data in one 16-bit transfer
    write_reg(3'd2, 3'd0, 32'h4F);
    read_reg(3'd2, 3'd1, "R4 R6 filter-high write/read");

    // R5: a long register written in one 32-clock transfer
    write_reg(3'd6, 3'd3, 32'hA5C33C);
    read_reg(3'd6, 3'd3, "R5 long register write/read");

    // R2: command-register write arms nothing
    xfer(8, 32'h00, 1'b0, r);
    mchan = 3'd0;
    read_reg(3'd2, 3'd4, "R2 command write keeps command phase");

    // R7, R8: result arrives, status bit readable
    strobe(24'h123456);
    check(drdy_n == 1'b0, "R7 drdy low after strobe", drdy_n, 0);
    read_reg(3'd0, 3'd2, "R8 status read with result pending");
    read_reg(3'd5, 3'd2, "R7 R4 R3 data read with din held high");
    check(drdy_n == 1'b1, "R7 drdy high after full read", drdy_n, 1);
    read_reg(3'd0, 3'd0, "R8 status read after result taken");

    // R5, R7: split long read
    strobe(24'hABCDEF);
    xfer(8, {24'd0, 8'h58}, 1'b0, r);
    mchan = 3'd0;
    xfer(8, 32'h0, 1'b1, a);
    repeat (H) @(negedge clk);
    xfer(8, 32'h0, 1'b1, b);
    check(drdy_n == 1'b0, "R7 drdy held low mid split read", drdy_n, 0);
    repeat (H) @(negedge clk);
    xfer(8, 32'h0, 1'b1, c);
    mdrdy = 1'b1;
    r = {8'd0, a[7:0], b[7:0], c[7:0]};
    check(r == 32'hABCDEF, "R5 split read value", r, 32'hABCDEF);
    check(drdy_n == 1'b1, "R7 drdy high after third byte", drdy_n, 1);

    // R11: data register ignores writes
    write_reg(3'd5, 3'd0, 32'h000000);
    read_reg(3'd5, 3'd0, "R11 data register unchanged by write");

    // R9: abort in the middle of an access
    xfer(8, {24'd0, 8'h10}, 1'b0, r);
    xfer(4, 32'hF, 1'b0, r);
    settled = 0;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(dout_en == 1'b0, "R9 dout_en low with cs high", dout_en, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    settled = 1;
    read_reg(3'd1, 3'd0, "R9 aborted write leaves mode unchanged");

    // R9: abort part-way through a command byte
    xfer(3, 32'h7, 1'b0, r);
    settled = 0;
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    settled = 1;
    read_reg(3'd3, 3'd6, "R9 realigned after aborted command");

    // R10: inverted clock polarity
    do_reset(1'b1);
    write_reg(3'd1, 3'd2, 32'h5A);
    read_reg(3'd1, 3'd2, "R10 mode write/read with pol high");
    write_reg(3'd4, 3'd1, 32'hC3);
    read_reg(3'd4, 3'd1, "R10 test register with pol high");
    strobe(24'h0F1E2D);
    read_reg(3'd5, 3'd5, "R10 R7 data read with pol high");
    check(drdy_n == 1'b1, "R10 R7 drdy released with pol high", drdy_n, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule